// File: doc/BRIEF.md
# Reference Pulse Phase Capture

This block helps software find the phase of a slow, periodic reference pulse that arrives synchronous to the sampling clock. A free-running divider counter runs at the pulse rate, counting modulo 128. Software can move its phase one step at a time with slip commands, and each command either skips a value or repeats one. A slip does not have to arrive in any particular cycle.

The block also holds a 5-bit delay-tap register that drives an external delay element. Software can read the tap back, so it always knows which tap is selected. When software arms a capture, the block records 128 consecutive single-flip-flop samples of the pulse. Each sample is tagged with the divider count of its cycle. Software reads the samples out and does the edge analysis itself.

An optional scan mode wraps the divider one cycle early. Successive pulse periods then fall on successive divider phases, which sweeps every offset.

Top module: `refpulse_phase_capture`

## Requirements
- R1: After reset the tap output is 0, the done flag is 0, a status read (address 2) returns 0, a slip read (address 1) returns 0, and the divider count is 0 in the first cycle after reset.
- R2: Outside scan mode, and with no slip applied, the divider count advances by one every cycle and wraps from 127 to 0. The 128 entries of a capture therefore carry consecutive tags, and entry k holds tag k.
- R3: A write to address 2 with bit 0 set arms a capture, and the arm is honoured only when the block is idle. The capture starts in the next cycle whose divider count is 0 and stores 128 entries. The done flag is raised in the same cycle that the last entry is written. While a capture is armed or running, status bit 1 (busy) reads 1, and status bit 0 mirrors done.
- R4: Each entry read from address 3, after the entry index has been written to address 3, has this layout: bits 7:1 hold the divider count of the sampled cycle, and bit 0 holds the pulse level in that same cycle.
- R5: A write to address 1 with bit 0 = 0 (skip) makes the divider advance by two on one cycle. The pulse is then seen at a tag one higher than before.
- R6: A write to address 1 with bit 0 = 1 (repeat) makes the divider hold its value for one cycle. The pulse is then seen at a tag one lower than before.
- R7: A slip written while a capture is armed or running is held pending, and slip read bit 0 returns 1 while it waits. The pending slip is applied only once done is set, so the capture in progress is undisturbed.
- R8: A write to address 0 loads the tap from bits 4:0. The tap appears on the tap output in the following cycle and reads back from address 0.
- R9: Any tap write clears the done flag.
- R10: Writing address 2 with bit 1 set enables scan mode, in which the divider wraps from 126 to 0. A scan-mode capture therefore holds tags 0 to 126 followed by 0. Status bit 2 reflects scan mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Reference pulse, synchronous to clk |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for both reads and writes |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| tapOut | output | 5 | Delay tap selection for the external delay element |
| doneOut | output | 1 | Capture complete and buffer valid |

## Verification
The pulse is driven one cycle wide at a fixed phase of a bench-side reference counter that mirrors the divider from reset. Each capture is then matched against a single expected tag. Captures are taken with no slip, after one skip, after two repeats, and with a slip issued mid-capture. These separate the direction and size of a slip, and they show whether a slip leaked into the capture it should wait for. A final scan-mode capture shows the early wrap at the end of the buffer, which a modulo-128 counter would not produce.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

  typedef enum logic [1:0] {
    REG_TAP  = 2'd0,
    REG_SLIP = 2'd1,
    REG_CTRL = 2'd2,
    REG_BUF  = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_CAPTURE = 2'd2
  } capState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tapWr;
    logic idxWr;
    logic modeWr;
    logic takeSample;
    logic slipApply;
    logic slipRepeat;
  } ctrlStrobe_t;

endpackage

// File: rtl/pcap_ctrl.sv
module pcap_ctrl
  import pcap_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              cntAtZero,
  output ctrlStrobe_t       strobe,
  output logic [IDX_W-1:0]  sampleIdx,
  output logic              done,
  output logic              busy,
  output logic              slipPending
);

  capState_e        state;
  logic [IDX_W-1:0] entryNum;
  logic             pendRepeat;
  logic             armReq;
  logic             slipWr;
  logic             lastEntry;

  assign armReq    = regWrEn && (regAddr == REG_CTRL) && regWrData[0];
  assign slipWr    = regWrEn && (regAddr == REG_SLIP);
  assign lastEntry = (state == ST_CAPTURE) && (entryNum == IDX_W'(DEPTH - 1));
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobe            = '0;
    strobe.tapWr      = regWrEn && (regAddr == REG_TAP);
    strobe.idxWr      = regWrEn && (regAddr == REG_BUF);
    strobe.modeWr     = regWrEn && (regAddr == REG_CTRL);
    strobe.takeSample = ((state == ST_ARMED) && cntAtZero) || (state == ST_CAPTURE);
    strobe.slipApply  = slipPending && (state == ST_IDLE);
    strobe.slipRepeat = pendRepeat;
  end

  assign sampleIdx = (state == ST_CAPTURE) ? entryNum : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      entryNum <= '0;
      done     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (armReq) begin
            state <= ST_ARMED;
            done  <= 1'b0;
          end
        end
        ST_ARMED: begin
          if (cntAtZero) begin
            state    <= ST_CAPTURE;
            entryNum <= IDX_W'(1);
          end
        end
        ST_CAPTURE: begin
          if (lastEntry) begin
            state    <= ST_IDLE;
            entryNum <= '0;
            done     <= 1'b1;
          end else begin
            entryNum <= entryNum + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (strobe.tapWr) done <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slipPending <= 1'b0;
      pendRepeat  <= 1'b0;
    end else if (slipWr) begin
      slipPending <= 1'b1;
      pendRepeat  <= regWrData[0];
    end else if (strobe.slipApply) begin
      slipPending <= 1'b0;
    end
  end

  // R9
  tap_clears_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tapWr |=> !done);

  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(strobe.takeSample && (sampleIdx == IDX_W'(DEPTH - 1))));

  // R7
  slip_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slipPending && (state == ST_CAPTURE) && !lastEntry) |=> slipPending);

  // R3
  arm_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_CAPTURE) && !lastEntry) |=> (state == ST_CAPTURE));

endmodule

// File: rtl/pcap_datapath.sv
module pcap_datapath
  import pcap_pkg::*;
#(
  parameter int PERIOD = 128,
  parameter int DEPTH  = 128,
  parameter int TAP_W  = 5,
  parameter int DATA_W = 8,
  localparam int CNT_W   = $clog2(PERIOD),
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int ENTRY_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseIn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  sampleIdx,
  input  logic              done,
  input  logic              busy,
  input  logic              slipPending,
  output logic              cntAtZero,
  output logic [TAP_W-1:0]  tapOut,
  output logic [DATA_W-1:0] regRdData
);

  logic [CNT_W-1:0]   divCnt;
  logic [TAP_W-1:0]   tapQ;
  logic               scanQ;
  logic [IDX_W-1:0]   rdIdx;
  logic [ENTRY_W-1:0] sampleMem [DEPTH];

  function automatic logic [CNT_W-1:0] stepCnt(input logic [CNT_W-1:0] v, input logic early);
    logic [CNT_W-1:0] lim;
    lim = early ? CNT_W'(PERIOD - 2) : CNT_W'(PERIOD - 1);
    return (v >= lim) ? '0 : v + 1'b1;
  endfunction

  // divider with slip
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strobe.slipApply) begin
      divCnt <= strobe.slipRepeat ? divCnt : stepCnt(stepCnt(divCnt, scanQ), scanQ);
    end else begin
      divCnt <= stepCnt(divCnt, scanQ);
    end
  end

  assign cntAtZero = (divCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tapQ  <= '0;
      scanQ <= 1'b0;
      rdIdx <= '0;
    end else begin
      if (strobe.tapWr)  tapQ  <= regWrData[TAP_W-1:0];
      if (strobe.modeWr) scanQ <= regWrData[1];
      if (strobe.idxWr)  rdIdx <= regWrData[IDX_W-1:0];
    end
  end

  // the memory bit itself is the single sampling flop
  always_ff @(posedge clk) begin
    if (strobe.takeSample) sampleMem[sampleIdx] <= {divCnt, pulseIn};
  end

  assign tapOut = tapQ;

  always_comb begin
    unique case (regAddr)
      REG_TAP:  regRdData = DATA_W'(tapQ);
      REG_SLIP: regRdData = DATA_W'(slipPending);
      REG_CTRL: regRdData = DATA_W'({scanQ, busy, done});
      default:  regRdData = DATA_W'(sampleMem[rdIdx]);
    endcase
  end

  // R2
  div_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!scanQ && !strobe.slipApply && (divCnt == CNT_W'(PERIOD - 1))) |=> (divCnt == '0));

  // R10
  scan_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (scanQ && !strobe.slipApply && (divCnt == CNT_W'(PERIOD - 2))) |=> (divCnt == '0));

  // R6
  repeat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.slipApply && strobe.slipRepeat) |=> $stable(divCnt));

  // R8
  tap_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tapWr |=> (tapOut == $past(regWrData[TAP_W-1:0])));

endmodule

// File: rtl/refpulse_phase_capture.sv
module refpulse_phase_capture
  import pcap_pkg::*;
#(
  parameter int PERIOD = 128,
  parameter int DEPTH  = 128,
  parameter int TAP_W  = 5,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseIn,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [TAP_W-1:0]  tapOut,
  output logic              doneOut
);

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] sampleIdx;
  logic             done;
  logic             busy;
  logic             slipPending;
  logic             cntAtZero;

  pcap_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .cntAtZero  (cntAtZero),
    .strobe     (strobe),
    .sampleIdx  (sampleIdx),
    .done       (done),
    .busy       (busy),
    .slipPending(slipPending)
  );

  pcap_datapath #(.PERIOD(PERIOD), .DEPTH(DEPTH), .TAP_W(TAP_W), .DATA_W(DATA_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pulseIn    (pulseIn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .strobe     (strobe),
    .sampleIdx  (sampleIdx),
    .done       (done),
    .busy       (busy),
    .slipPending(slipPending),
    .cntAtZero  (cntAtZero),
    .tapOut     (tapOut),
    .regRdData  (regRdData)
  );

  assign doneOut = done;

endmodule

// File: tb/test_refpulse_phase_capture.sv
`timescale 1ns/1ps
module test_refpulse_phase_capture;

  localparam int PER   = 128;
  localparam int PHASE = 37;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pulseIn = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic [4:0] tapOut;
  logic       doneOut;

  int nTests = 0;
  int nFail = 0;
  int refCnt = 0;
  int offset = 0;
  bit finished = 0;
  int expQ[$];
  int maskQ[$];
  string reqQ[$];

  always #2 clk = ~clk;

  refpulse_phase_capture i_refpulse_phase_capture (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .tapOut(tapOut), .doneOut(doneOut)
  );

  // bench-side reference counter mirrors an unslipped divider
  always @(posedge clk) begin
    if (!rstN) refCnt <= 0;
    else       refCnt <= (refCnt + 1) % PER;
  end
  always @(negedge clk) pulseIn <= (refCnt == PHASE);

  task automatic chk(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(int addr, int data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'(addr); regWrData = 8'(data);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(int addr, output int data);
    @(negedge clk);
    regAddr = 2'(addr);
    #1 data = int'(regRdData);
  endtask

  task automatic waitDone(string req);
    int n = 0;
    while (!doneOut && n < 600) begin @(negedge clk); n++; end
    chk(req, int'(doneOut), 1);
  endtask

  // driver: expected entries into the scoreboard
  task automatic pushCapture(int pulseTag, bit scan, string req);
    for (int k = 0; k < PER; k++) begin
      int tag;
      tag = scan ? (k % (PER - 1)) : k;
      expQ.push_back((tag << 1) | ((!scan && tag == pulseTag) ? 1 : 0));
      maskQ.push_back(scan ? 8'hFE : 8'hFF);
      reqQ.push_back(req);
    end
  endtask

  // monitor: read buffer and compare against the scoreboard
  task automatic drainCapture();
    for (int k = 0; k < PER; k++) begin
      int v, e, m;
      string r;
      wrReg(3, k);
      rdReg(3, v);
      e = expQ.pop_front(); m = maskQ.pop_front(); r = reqQ.pop_front();
      chk(r, v & m, e & m);
    end
  endtask

  task automatic runCapture(int armWord, int pulseTag, bit scan, string req);
    int st;
    wrReg(2, armWord);
    rdReg(2, st);
    chk("R3 busy after arm", (st >> 1) & 1, 1);
    waitDone(req);
    pushCapture(pulseTag, scan, req);
    drainCapture();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 tap", int'(tapOut), 0);
    chk("R1 done", int'(doneOut), 0);
    rdReg(2, v); chk("R1 status", v, 0);
    rdReg(1, v); chk("R1 slip", v, 0);

    // R8 tap write and readback
    wrReg(0, 8'h15);
    rdReg(0, v); chk("R8 readback", v, 8'h15);
    chk("R8 tapOut", int'(tapOut), 8'h15);

    // R2 R3 R4 plain capture (R1 alignment: divider at 0 after reset)
    runCapture(1, PHASE, 0, "R4 R2 plain capture");
    rdReg(2, v); chk("R3 done status", v & 3, 1);

    // R9 tap write clears done
    wrReg(0, 8'h0A);
    chk("R9 done cleared", int'(doneOut), 0);
    rdReg(0, v); chk("R8 second readback", v, 8'h0A);

    // R5 skip
    wrReg(1, 0); offset += 1;
    repeat (3) @(negedge clk);
    rdReg(1, v); chk("R5 slip consumed", v, 0);
    runCapture(1, (PHASE + offset) % PER, 0, "R5 skip shift");

    // R6 two repeats
    wrReg(1, 1); wrReg(1, 1); offset -= 2;
    repeat (3) @(negedge clk);
    runCapture(1, (PHASE + offset + PER) % PER, 0, "R6 repeat shift");

    // R7 slip during capture is held
    wrReg(2, 1);
    wrReg(1, 0);
    rdReg(1, v); chk("R7 pending while busy", v, 1);
    waitDone("R7 done");
    pushCapture((PHASE + offset + PER) % PER, 0, "R7 capture undisturbed");
    drainCapture();
    rdReg(1, v); chk("R7 applied after done", v, 0);
    offset += 1;
    runCapture(1, (PHASE + offset + PER) % PER, 0, "R7 shift after done");

    // R10 scan mode
    runCapture(3, 0, 1, "R10 scan wrap");
    rdReg(2, v); chk("R10 scan status", (v >> 2) & 1, 1);
    wrReg(2, 0);
    rdReg(2, v); chk("R10 scan off", (v >> 2) & 1, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule